// File: doc/BRIEF.md
# Address-Generation Register Slice

This block is the register-and-adder core of an address-generation unit. It keeps three general registers, typically used as program counter, stack pointer and operand address, and a separate output register. In every cycle an adder forms the sum of the external data operand, one selected register (or zero) and a carry input. On an executed clock edge that sum is written into a destination register and into the output register. A 4-bit instruction chooses the operand register, the destination and what the address bus shows.

The datapath is a chain of 4-bit slices with a rippled carry, so the word width is a parameter that must be a multiple of 4. The external data input, the carry input, the carry output and the data output are all active low. The address and data outputs are three-state at the pins. Here each is modelled as a driven value plus a valid flag: a disabled output drives all ones and lowers its flag.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, R0, R1, R2 and the output register all hold zero.
- R2: The sum is (~d_n) + operand + (~ci_n), taken modulo 2^W. co_n is LOW exactly when this addition carries out of the top bit.
- R3: instr[3:1] selects the adder operand as follows: 000 and 110 select R0; 001 and 111 select R1; 010 selects R2; 011, 100 and 101 select zero.
- R4: instr[3:1] selects the destination as follows: 000 and 011 write R0; 001 and 100 write R1; 010, 101, 110 and 111 write R2.
- R5: A rising clk edge with exec_n HIGH changes no register and does not change the output register.
- R6: A rising clk edge with exec_n LOW writes the sum into the destination register and into the output register. When enabled, data_out_n shows the bitwise inverse of the output register.
- R7: When instr[0] is HIGH and addr_oe_n is LOW, addr_out shows the live sum. This holds for either level of exec_n.
- R8: When instr[0] is LOW and addr_oe_n is LOW, addr_out shows the operand register selected by instr[3:1]. It shows zero when no register is selected.
- R9: When addr_oe_n is HIGH, addr_out is all ones and addr_valid is LOW. When data_oe_n is HIGH, data_out_n is all ones and data_valid is LOW. When an enable is LOW, its valid flag is HIGH.
- R10: With W=16, a carry ripples through all four slices. For example, 0x0FFF + 1 gives 0x1000, and 0xFFFF + 1 gives 0x0000 with co_n LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_n | input | 1 | Active-low execute; qualifies register writes |
| instr | input | 4 | Instruction: [3:1] selects the operand and destination, [0] selects the address source |
| d_n | input | W | External data operand, active low |
| ci_n | input | 1 | Carry in, active low |
| co_n | output | 1 | Carry out, active low |
| addr_oe_n | input | 1 | Address output enable, active low |
| data_oe_n | input | 1 | Data output enable, active low |
| addr_out | output | W | Address bus value |
| addr_valid | output | 1 | High when addr_out is being driven |
| data_out_n | output | W | Output register contents, active low |
| data_valid | output | 1 | High when data_out_n is being driven |

## Verification
A wrong register value does not appear at the ports until an instruction selects that register. It then shows at once on addr_out when instr[0] is LOW, and one edge later on data_out_n after an executed operation that uses it. For that reason every operation is followed by reads through each selector code. A write that lands in the wrong destination, or a write taken when exec_n is HIGH, shows up at the first later read of the register it damaged. A broken carry link shows in the same cycle, on addr_out in live-sum mode and on co_n.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int SLICE_W = 4;

  typedef enum logic [1:0] {
    SEL_R0   = 2'd0,
    SEL_R1   = 2'd1,
    SEL_R2   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e src;
    reg_sel_e dst;
  } agu_ctrl_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [2:0] op,
  output agu_ctrl_t  ctrl
);
  always_comb begin
    ctrl.src = SEL_NONE;
    ctrl.dst = SEL_R0;
    unique case (op)
      3'b000: begin ctrl.src = SEL_R0;   ctrl.dst = SEL_R0; end
      3'b001: begin ctrl.src = SEL_R1;   ctrl.dst = SEL_R1; end
      3'b010: begin ctrl.src = SEL_R2;   ctrl.dst = SEL_R2; end
      3'b011: begin ctrl.src = SEL_NONE; ctrl.dst = SEL_R0; end
      3'b100: begin ctrl.src = SEL_NONE; ctrl.dst = SEL_R1; end
      3'b101: begin ctrl.src = SEL_NONE; ctrl.dst = SEL_R2; end
      3'b110: begin ctrl.src = SEL_R0;   ctrl.dst = SEL_R2; end
      default: begin ctrl.src = SEL_R1;  ctrl.dst = SEL_R2; end
    endcase
  end
endmodule

// File: rtl/agu_add_slice.sv
module agu_add_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          ci_n,
  output logic [SW-1:0] s,
  output logic          co_n
);
  logic [SW:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, ~ci_n};
    s     = total[SW-1:0];
    co_n  = ~total[SW];
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     dst,
  input  reg_sel_e     src,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] src_data,
  output logic [W-1:0] out_q
);
  localparam int NREG = 3;

  logic [NREG-1:0][W-1:0] r_q, r_d;
  logic [W-1:0]           out_d;

  always_comb begin
    r_d   = r_q;
    out_d = out_q;
    if (wr_en) begin
      out_d = wdata;
      for (int k = 0; k < NREG; k++) begin
        if (dst == reg_sel_e'(k)) r_d[k] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q   <= '0;
      out_q <= '0;
    end else begin
      r_q   <= r_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    unique case (src)
      SEL_R0:  src_data = r_q[0];
      SEL_R1:  src_data = r_q[1];
      SEL_R2:  src_data = r_q[2];
      default: src_data = '0;
    endcase
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_n,
  input  logic [3:0]   instr,
  input  logic [W-1:0] d_n,
  input  logic         ci_n,
  output logic         co_n,
  input  logic         addr_oe_n,
  input  logic         data_oe_n,
  output logic [W-1:0] addr_out,
  output logic         addr_valid,
  output logic [W-1:0] data_out_n,
  output logic         data_valid
);
  localparam int NS = W / SLICE_W;

  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  agu_ctrl_t    ctrl;
  logic [W-1:0] src_data;
  logic [W-1:0] sum;
  logic [W-1:0] out_q;
  logic [W-1:0] d_true;
  logic [NS:0]  carry_n;
  logic         wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  agu_decode u_dec (
    .op   (instr[3:1]),
    .ctrl (ctrl)
  );

  assign wr_en  = ~exec_n;
  assign d_true = ~d_n;

  agu_regfile #(.W(W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .dst      (ctrl.dst),
    .src      (ctrl.src),
    .wdata    (sum),
    .src_data (src_data),
    .out_q    (out_q)
  );

  assign carry_n[0] = ci_n;
  for (genvar g = 0; g < NS; g++) begin : g_slice
    agu_add_slice #(.SW(SLICE_W)) u_add (
      .a    (d_true[g*SLICE_W +: SLICE_W]),
      .b    (src_data[g*SLICE_W +: SLICE_W]),
      .ci_n (carry_n[g]),
      .s    (sum[g*SLICE_W +: SLICE_W]),
      .co_n (carry_n[g+1])
    );
  end
  assign co_n = carry_n[NS];

  always_comb begin
    addr_valid = ~addr_oe_n;
    if (addr_oe_n)     addr_out = '1;
    else if (instr[0]) addr_out = sum;
    else               addr_out = src_data;
    data_valid = ~data_oe_n;
    data_out_n = data_oe_n ? '1 : ~out_q;
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_n,
  input logic [3:0]   instr,
  input logic         addr_oe_n,
  input logic [W-1:0] addr_out,
  input logic         addr_valid,
  input logic [W-1:0] sum,
  input logic [W-1:0] out_q,
  input logic [1:0]   src_sel
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_n |=> $stable(out_q));

  assert_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_n |=> out_q == $past(sum));

  assert_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[0] && !addr_oe_n) |-> addr_out == sum);

  assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr[0] && !addr_oe_n && src_sel == 2'd3) |-> addr_out == '0);

  assert_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe_n |-> (addr_out == '1 && !addr_valid));
endmodule

bind addr_gen_unit agu_checker #(.W(W)) u_agu_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .exec_n    (exec_n),
  .instr     (instr),
  .addr_oe_n (addr_oe_n),
  .addr_out  (addr_out),
  .addr_valid(addr_valid),
  .sum       (sum),
  .out_q     (out_q),
  .src_sel   (ctrl.src)
);

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] addr;
    logic         av;
    logic [W-1:0] dout;
    logic         dv;
    logic         co_n;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, exec_n, ci_n, co_n, addr_oe_n, data_oe_n, addr_valid, data_valid;
  logic [3:0]   instr;
  logic [W-1:0] d_n, addr_out, data_out_n;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  event item_ev;
  logic [W-1:0] m_reg [3];
  logic [W-1:0] m_out;

  always #4 clk = ~clk;

  addr_gen_unit #(.W(W)) i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .exec_n(exec_n), .instr(instr), .d_n(d_n),
    .ci_n(ci_n), .co_n(co_n), .addr_oe_n(addr_oe_n), .data_oe_n(data_oe_n),
    .addr_out(addr_out), .addr_valid(addr_valid), .data_out_n(data_out_n),
    .data_valid(data_valid)
  );

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "addr_out", addr_out, e.addr);
        cmp(e.tag, "addr_valid", {{(W-1){1'b0}}, addr_valid}, {{(W-1){1'b0}}, e.av});
        cmp(e.tag, "data_out_n", data_out_n, e.dout);
        cmp(e.tag, "data_valid", {{(W-1){1'b0}}, data_valid}, {{(W-1){1'b0}}, e.dv});
        cmp(e.tag, "co_n", {{(W-1){1'b0}}, co_n}, {{(W-1){1'b0}}, e.co_n});
      end
    end
  end

  // driver: drive one cycle, push the expected outputs, update the model
  task automatic op(input logic [3:0] ins, input logic [W-1:0] dval, input logic cin,
                    input logic ex_n, input logic aoe_n, input logic doe_n, input string tag);
    logic [W-1:0] src;
    logic [W:0]   s;
    int           dst;
    exp_t         e;
    @(negedge clk);
    instr = ins; d_n = ~dval; ci_n = ~cin; exec_n = ex_n;
    addr_oe_n = aoe_n; data_oe_n = doe_n;
    case (ins[3:1])
      3'b000, 3'b110: src = m_reg[0];
      3'b001, 3'b111: src = m_reg[1];
      3'b010:         src = m_reg[2];
      default:        src = '0;
    endcase
    case (ins[3:1])
      3'b000, 3'b011: dst = 0;
      3'b001, 3'b100: dst = 1;
      default:        dst = 2;
    endcase
    s = {1'b0, dval} + {1'b0, src} + {{W{1'b0}}, cin};
    e.addr = aoe_n ? '1 : (ins[0] ? s[W-1:0] : src);
    e.av   = ~aoe_n;
    e.dout = doe_n ? '1 : ~m_out;
    e.dv   = ~doe_n;
    e.co_n = ~s[W];
    e.tag  = tag;
    sb.push_back(e);
    ->item_ev;
    @(posedge clk);
    if (!ex_n) begin
      m_reg[dst] = s[W-1:0];
      m_out      = s[W-1:0];
    end
  endtask

  task automatic read_all(input string tag);
    op(4'b0000, '0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
    op(4'b0010, '0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
    op(4'b0100, '0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_reg[0] = '0; m_reg[1] = '0; m_reg[2] = '0; m_out = '0;
    rst_n = 1'b0; exec_n = 1'b1; instr = '0; d_n = '1; ci_n = 1'b1;
    addr_oe_n = 1'b0; data_oe_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state, all registers and output register zero
    read_all("R1");
    op(4'b0110, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R1_R8");
    // R4 R6: loads with no operand register
    op(4'b0110, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R4_R8");
    op(4'b1000, 16'h2345, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    op(4'b1010, 16'h00F0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    read_all("R6");
    // R10: increment with carry across slices
    op(4'b0001, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    read_all("R10");
    // R3 R2: each operand selection, carry in added
    op(4'b1100, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    op(4'b1110, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    op(4'b0010, 16'h1111, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    op(4'b0100, 16'hFFF0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    read_all("R3");
    // R5: no write when execute is HIGH
    op(4'b0000, 16'h4444, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    op(4'b1011, 16'h7777, 1'b0, 1'b1, 1'b0, 1'b0, "R5_R7");
    read_all("R5");
    // R7: live sum on the address bus, executed and not
    op(4'b0101, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    op(4'b0011, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    // R2 R10: full overflow
    op(4'b0110, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    op(4'b0001, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R2_R10");
    op(4'b0001, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    // R9: output enables
    op(4'b0001, 16'h0055, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    op(4'b0000, 16'h0055, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    op(4'b0000, 16'h0055, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    read_all("R9");
    @(negedge clk); #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule